// File: doc/BRIEF.md
# External Interrupt Detection Controller

This block turns 32 external interrupt pins, grouped as four banks of eight, into interrupt requests for a downstream interrupt controller. Every pin first crosses into the clock domain through a two-flop synchroniser. A per-pin trigger detector then decides, cycle by cycle, whether the pin's event is present. A detected event sets that pin's sticky pending bit.

Software programs the block through a word-addressed register port with combinational reads. There are four register groups, each holding one word per bank: trigger configuration, filter storage, mask and pending. A mask bit only gates the interrupt outputs. The pending bit is still recorded while the pin is masked. Pins 0 to 15 each have a dedicated output line. Pins 16 to 31 are OR-merged into one shared line.

Each pin's detector behaves as a small selector over five trigger modes:

| Code | Mode | Fires when |
|---|---|---|
| 0 | LOW | the synchronised level is low |
| 1 | HIGH | the synchronised level is high |
| 2 | FALL | the level goes from high to low |
| 3 | RISE | the level goes from low to high |
| 4 | BOTH | the level changes in either direction |
| 5, 6, 7 | reserved | never |

Each pending bit has two states, IDLE and PENDING, and moves between them as follows:
- IDLE→PENDING happens on a detected event.
- PENDING→IDLE happens on a write of 1 to that bit when no event is present in the same cycle.
- PENDING→PENDING happens when an event coincides with the clear.

Top module: `eic_top`

## Requirements
- R1: Under reset, all configuration, filter and pending words read 0. Every mask word reads 0x000000FF (all eight pins masked). Both interrupt outputs are 0.
- R2: The register groups have these byte offsets: configuration at 0xE00, filter at 0xE80, mask at 0xF00 and pending at 0xF40. Bank b sits at the group offset plus 4·b. Configuration and filter words store and read back all 32 bits. Mask and pending words use bits 7:0, where bit k is pin 8·b+k, and read back zero-extended. The filter word has no effect on detection.
- R3: Codes 0 (low level) and 1 (high level) set the pending bit in every cycle that the level persists, so a clear does not remove it while the level remains.
- R4: Codes 2 (falling), 3 (rising) and 4 (both) set the pending bit once per matching transition. A clear removes the bit even while the new level remains. A non-matching transition sets nothing.
- R5: Mode codes 5, 6 and 7 never set a pending bit, whatever the pin does.
- R6: A mask bit of 1 blocks the pin from the outputs but does not stop its pending bit from being set. Clearing the mask bit exposes a bit that is already pending.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: When a detected event and a write-1 clear hit the same bit in the same cycle, the bit remains pending.
- R9: irq_direct[i] equals pending AND NOT mask for pin i, for i < 16. irq_shared is the OR of pending AND NOT mask over pins 16 to 31.
- R10: A pin transition driven between two clock edges shows up as pending after the third rising edge that follows it, and not after the second.
- R11: Pin i's trigger code sits in bits [4·(i mod 8)+2 : 4·(i mod 8)] of configuration word i/8. Bit 4·(i mod 8)+3 is stored but ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 32 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_direct | output | 16 | Dedicated interrupt lines for pins 0 to 15 |
| irq_shared | output | 1 | Merged interrupt line for pins 16 to 31 |

## Verification
The assertions take for granted the following about the inputs:
- The write strobe, address and data are stable around each rising edge.
- External pins may change at any time, because they are only looked at after the synchroniser.

The stimulus meets this by changing every input only on the falling clock edge and by sampling results one nanosecond after that edge. Pin pulses are held for at least four cycles so that edge and level modes resolve deterministically. The only exception is the R8 collision case, where the write is placed deliberately on the edge that records the event.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CFG = 12'hE00;
    localparam logic [ADDR_W-1:0] OFS_FLT = 12'hE80;
    localparam logic [ADDR_W-1:0] OFS_MSK = 12'hF00;
    localparam logic [ADDR_W-1:0] OFS_PND = 12'hF40;

    typedef enum logic [2:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_mode_e;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_CFG,
        GRP_FLT,
        GRP_MSK,
        GRP_PND
    } reg_grp_e;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    // Two stages resolve metastability; a third holds last cycle's value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;

endmodule

// File: rtl/eic_detect.sv
module eic_detect
    import eic_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int SLOT_W = 4
) (
    input  logic [NPINS-1:0]        cur,
    input  logic [NPINS-1:0]        prev,
    input  logic [NPINS*SLOT_W-1:0] cfg,
    output logic [NPINS-1:0]        hit
);
    localparam int MODE_W = 3;

    // Only the low MODE_W bits of each slot select a mode
    logic unused_cfg;
    assign unused_cfg = ^cfg;

    function automatic logic fire(input logic [MODE_W-1:0] code,
                                  input logic c, input logic p);
        logic r;
        unique case (trig_mode_e'(code))
            TRIG_LOW:  r = ~c;
            TRIG_HIGH: r = c;
            TRIG_FALL: r = p & ~c;
            TRIG_RISE: r = c & ~p;
            TRIG_BOTH: r = c ^ p;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign hit[i] = fire(cfg[i*SLOT_W +: MODE_W], cur[i], prev[i]);
    end

endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 8,
    parameter int SLOT_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   set_vec,
    output logic [NUM_BANKS*DATA_W-1:0]   cfg_flat,
    output logic [NUM_BANKS*BANK_W-1:0]   mask_flat,
    output logic [NUM_BANKS*BANK_W-1:0]   pend_flat
);
    localparam int NPINS = NUM_BANKS * BANK_W;
    localparam int BIW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int LSB   = 2 + BIW;

    logic [DATA_W-1:0] cfg_q [NUM_BANKS];
    logic [DATA_W-1:0] flt_q [NUM_BANKS];
    logic [BANK_W-1:0] msk_q [NUM_BANKS];
    logic [NPINS-1:0]  pend_q;
    logic [NPINS-1:0]  pend_d;
    logic [NPINS-1:0]  clr_vec;
    logic [BIW-1:0]    bank;
    reg_grp_e          grp;

    logic unused_addr;
    assign unused_addr = ^addr[1:0];

    assign bank = addr[2 +: BIW];

    always_comb begin
        grp = GRP_NONE;
        if (addr[ADDR_W-1:LSB] == OFS_CFG[ADDR_W-1:LSB])
            grp = GRP_CFG;
        else if (addr[ADDR_W-1:LSB] == OFS_FLT[ADDR_W-1:LSB])
            grp = GRP_FLT;
        else if (addr[ADDR_W-1:LSB] == OFS_MSK[ADDR_W-1:LSB])
            grp = GRP_MSK;
        else if (addr[ADDR_W-1:LSB] == OFS_PND[ADDR_W-1:LSB])
            grp = GRP_PND;
    end

    // Write-1-to-clear vector for the addressed pending word
    always_comb begin
        clr_vec = '0;
        if (wr && grp == GRP_PND)
            clr_vec[bank*BANK_W +: BANK_W] = wdata[BANK_W-1:0];
    end

    // A new event outranks a clear in the same cycle
    assign pend_d = (pend_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                cfg_q[b] <= '0;
                flt_q[b] <= '0;
                msk_q[b] <= '1;
            end
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr) begin
                unique case (grp)
                    GRP_CFG: cfg_q[bank] <= wdata;
                    GRP_FLT: flt_q[bank] <= wdata;
                    GRP_MSK: msk_q[bank] <= wdata[BANK_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (grp)
            GRP_CFG: rdata = cfg_q[bank];
            GRP_FLT: rdata = flt_q[bank];
            GRP_MSK: rdata = DATA_W'(msk_q[bank]);
            GRP_PND: rdata = DATA_W'(pend_q[bank*BANK_W +: BANK_W]);
            default: rdata = '0;
        endcase
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flat
        assign cfg_flat[b*DATA_W +: DATA_W]  = cfg_q[b];
        assign mask_flat[b*BANK_W +: BANK_W] = msk_q[b];
    end
    assign pend_flat = pend_q;

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0))
        else $error("pending bit dropped without a clear"); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_vec) & ~pend_q) == '0))
        else $error("event did not leave bit pending"); // R8
    AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0))
        else $error("pending bit rose without an event"); // R3

endmodule

// File: rtl/eic_top.sv
module eic_top
    import eic_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BANK_W      = 8,
    parameter int SLOT_W      = 4,
    parameter int DATA_W      = 32,
    parameter int DIRECT_PINS = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0]   ext_pin,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [DIRECT_PINS-1:0]        irq_direct,
    output logic                          irq_shared
);
    localparam int NPINS = NUM_BANKS * BANK_W;

    logic [NPINS-1:0]           pin_cur;
    logic [NPINS-1:0]           pin_prev;
    logic [NPINS-1:0]           hit_vec;
    logic [NUM_BANKS*DATA_W-1:0] cfg_flat;
    logic [NPINS-1:0]           mask_flat;
    logic [NPINS-1:0]           pend_flat;
    logic [NPINS-1:0]           live;

    eic_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (ext_pin),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    eic_detect #(.NPINS(NPINS), .SLOT_W(SLOT_W)) u_detect (
        .cur (pin_cur),
        .prev(pin_prev),
        .cfg (cfg_flat),
        .hit (hit_vec)
    );

    eic_regs #(
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W),
        .SLOT_W   (SLOT_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .set_vec  (hit_vec),
        .cfg_flat (cfg_flat),
        .mask_flat(mask_flat),
        .pend_flat(pend_flat)
    );

    assign live       = pend_flat & ~mask_flat;
    assign irq_direct = live[DIRECT_PINS-1:0];
    assign irq_shared = |live[NPINS-1:DIRECT_PINS];

    AST_DIRECT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_direct & ~$past(irq_direct) & ~$past(hit_vec[DIRECT_PINS-1:0])
                   & ~$past(mask_flat[DIRECT_PINS-1:0])) == '0))
        else $error("direct line rose with no event and no unmask"); // R6
    AST_SHARED_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_flat[NPINS-1:DIRECT_PINS]) |-> !irq_shared)
        else $error("shared line active while every source masked"); // R9

endmodule

// File: tb/sim_eic_top.sv
`timescale 1ns/1ps
module sim_eic_top;

    localparam logic [11:0] A_CFG = 12'hE00;
    localparam logic [11:0] A_FLT = 12'hE80;
    localparam logic [11:0] A_MSK = 12'hF00;
    localparam logic [11:0] A_PND = 12'hF40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ext_pin = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_direct;
    logic        irq_shared;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
        logic [31:0] m;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    eic_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_direct(irq_direct),
        .irq_shared(irq_shared)
    );

    // Monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        #1;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {16'h0, irq_direct};
                default: act = {31'h0, irq_shared};
            endcase
            n_run++;
            if ((act & it.m) !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act & it.m, it.exp);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [11:0] a,
                          input logic [31:0] m, input logic [31:0] e);
        @(negedge clk);
        bus_addr = a;
        q.push_back('{tag, 0, e, m});
    endtask

    task automatic chk_irq(input string tag, input int kind,
                           input logic [31:0] m, input logic [31:0] e);
        @(negedge clk);
        q.push_back('{tag, kind, e, m});
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        ext_pin[i] = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state, read during reset
        chk_rd("R1 cfg0 reset", A_CFG, 32'hFFFF_FFFF, 32'h0);
        chk_rd("R1 mask3 reset", A_MSK + 12'hC, 32'hFFFF_FFFF, 32'h0000_00FF);
        chk_rd("R1 pend0 reset", A_PND, 32'hFFFF_FFFF, 32'h0);
        chk_irq("R1 direct reset", 1, 32'hFFFF, 32'h0);
        chk_irq("R1 shared reset", 2, 32'h1, 32'h0);
        wait_cyc(2);
        rst_n = 1'b1;

        // Quiet setup: all pins reserved mode, all unmasked, pend cleared
        for (int b = 0; b < 4; b++) wr(A_CFG + 12'(4*b), 32'h5555_5555);
        for (int b = 0; b < 4; b++) wr(A_MSK + 12'(4*b), 32'h0);
        wait_cyc(2);
        for (int b = 0; b < 4; b++) wr(A_PND + 12'(4*b), 32'hFF);

        // R2: address map and readback
        wr(A_FLT + 12'h4, 32'hA5A5_1234);
        chk_rd("R2 filter bank1 readback", A_FLT + 12'h4, 32'hFFFF_FFFF, 32'hA5A5_1234);
        chk_rd("R2 filter bank0 untouched", A_FLT, 32'hFFFF_FFFF, 32'h0);
        chk_rd("R2 cfg bank2 readback", A_CFG + 12'h8, 32'hFFFF_FFFF, 32'h5555_5555);
        chk_rd("R2 mask bank2 zero", A_MSK + 12'h8, 32'hFFFF_FFFF, 32'h0);

        // R5: reserved codes never set
        wr(A_CFG, 32'h5555_7555);
        set_pin(3, 1'b1); wait_cyc(4);
        set_pin(3, 1'b0); wait_cyc(4);
        chk_rd("R5 reserved codes 5/7 pin3", A_PND, 32'hFFFF_FFFF, 32'h0);

        // R3 + R11 + R9: high level on pin2 (slot bits 10:8 = 1, bit 11 set is ignored)
        wr(A_CFG, 32'h5555_5955);
        set_pin(2, 1'b1); wait_cyc(4);
        chk_rd("R3 high level sets pin2", A_PND, 32'hFF, 32'h04);
        chk_irq("R9 direct exact pin2", 1, 32'hFFFF, 32'h0004);
        wr(A_PND, 32'h04);
        chk_rd("R3 level persists after clear", A_PND, 32'hFF, 32'h04);
        set_pin(2, 1'b0); wait_cyc(4);
        wr(A_PND, 32'h04);
        chk_rd("R3 cleared once level gone", A_PND, 32'hFF, 32'h00);

        // R3: low level on pin0 (pin held low)
        wr(A_CFG, 32'h5555_5550);
        wait_cyc(3);
        chk_rd("R3 low level sets pin0", A_PND, 32'hFF, 32'h01);
        set_pin(0, 1'b1); wait_cyc(4);
        wr(A_PND, 32'h01);
        chk_rd("R3 low level released", A_PND, 32'hFF, 32'h00);
        wr(A_CFG, 32'h5555_5555);

        // R4: rising pin9, falling pin12
        wr(A_CFG + 12'h4, 32'h5555_5535);
        set_pin(9, 1'b1); wait_cyc(4);
        chk_rd("R4 rising sets pin9", A_PND + 12'h4, 32'hFF, 32'h02);
        chk_irq("R9 direct pin9", 1, 32'h0200, 32'h0200);
        wr(A_PND + 12'h4, 32'h02);
        chk_rd("R4 edge clear holds while high", A_PND + 12'h4, 32'hFF, 32'h00);
        set_pin(9, 1'b0); wait_cyc(4);
        chk_rd("R4 falling ignored in rise mode", A_PND + 12'h4, 32'hFF, 32'h00);
        wr(A_CFG + 12'h4, 32'h5552_5535);
        set_pin(12, 1'b1); wait_cyc(4);
        chk_rd("R4 rise ignored in fall mode", A_PND + 12'h4, 32'hFF, 32'h00);
        set_pin(12, 1'b0); wait_cyc(4);
        chk_rd("R4 falling sets pin12", A_PND + 12'h4, 32'hFF, 32'h10);
        wr(A_PND + 12'h4, 32'hFF);

        // R4 + R9: both edges on pin20, shared output
        wr(A_CFG + 12'h8, 32'h5554_5555);
        set_pin(20, 1'b1); wait_cyc(4);
        chk_rd("R4 both: rise sets pin20", A_PND + 12'h8, 32'hFF, 32'h10);
        chk_irq("R9 shared from pin20", 2, 32'h1, 32'h1);
        wr(A_PND + 12'h8, 32'h10);
        chk_irq("R9 shared drops after clear", 2, 32'h1, 32'h0);
        set_pin(20, 1'b0); wait_cyc(4);
        chk_rd("R4 both: fall sets pin20", A_PND + 12'h8, 32'hFF, 32'h10);
        wr(A_PND + 12'h8, 32'hFF);

        // R10: latency on pin17 rising
        wr(A_CFG + 12'h8, 32'h5555_5535);
        set_pin(17, 1'b1);
        wait_cyc(1);
        chk_rd("R10 not pending after two edges", A_PND + 12'h8, 32'h02, 32'h00);
        chk_rd("R10 pending after three edges", A_PND + 12'h8, 32'h02, 32'h02);
        wr(A_PND + 12'h8, 32'hFF);

        // R6 + R7: masked pin24 still records
        wr(A_CFG + 12'hC, 32'h5555_5553);
        wr(A_MSK + 12'hC, 32'h01);
        set_pin(24, 1'b1); wait_cyc(4);
        chk_rd("R6 masked pin24 still pending", A_PND + 12'hC, 32'hFF, 32'h01);
        chk_irq("R6 shared blocked by mask", 2, 32'h1, 32'h0);
        wr(A_MSK + 12'hC, 32'h00);
        chk_irq("R6 unmask exposes pending", 2, 32'h1, 32'h1);
        wr(A_PND + 12'hC, 32'h00);
        chk_rd("R7 write 0 keeps pending", A_PND + 12'hC, 32'hFF, 32'h01);
        wr(A_PND + 12'hC, 32'h01);
        chk_rd("R7 write 1 clears", A_PND + 12'hC, 32'hFF, 32'h00);

        // R8: clear lands on the edge that records pin25's event
        wr(A_CFG + 12'hC, 32'h5555_5535);
        set_pin(25, 1'b1);
        wait_cyc(1);
        wr(A_PND + 12'hC, 32'h02);
        chk_rd("R8 set wins over clear", A_PND + 12'hC, 32'hFF, 32'h02);
        wr(A_PND + 12'hC, 32'h02);
        chk_rd("R8 later clear works", A_PND + 12'hC, 32'hFF, 32'h00);

        wait_cyc(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule